// File: doc/BRIEF.md
# Configurable Serial Audio Data Shifter

This block sits between a parallel sample stream and a one-bit serial audio data line. On the transmit side it takes 32-bit buffer words over a valid/ready handshake. At every frame-start strobe it extracts an 8-, 16- or 32-bit sample from the word and sends it out one bit per drive strobe. On the receive side it restarts at each frame-start strobe and collects one bit per sample strobe. When the configured number of bits has arrived, it places the sample into a 32-bit buffer word and offers that word over a valid/ready handshake. An external clock generator supplies the frame-start, drive and sample strobes as single-cycle pulses in the `clk` domain.

The sample can sit at the top or the bottom of the buffer word, and it can be sent or received most-significant bit first or least-significant bit first. If no transmit word is offered at a frame start, the block raises a sticky underrun flag. It then either holds the data line low for the whole frame or sends the last accepted word again, depending on a configuration pin. If a receive word completes while the previous one is still waiting, the new word is dropped and a sticky overrun flag is raised.

The configuration pins must stay static while a frame is in progress. Back-pressure rules are as follows. On transmit, `tx_ready` is high only in frame-start cycles, and a word is taken only when `tx_valid` is high in that same cycle. On receive, `rx_valid` stays high and `rx_word` stays constant until a cycle with `rx_ready` high.

Top module: `audio_shifter`

## Requirements
- R1: After reset, `tx_sd`, `rx_valid`, `underrun` and `overrun` are all 0.
- R2: `tx_ready` equals `frame_start`. A transmit word is accepted exactly when `frame_start` and `tx_valid` are both high in the same cycle.
- R3: The sample size is chosen by `cfg_size`: code 0 gives 8 bits, code 1 gives 16 bits, and codes 2 and 3 give 32 bits. Exactly that many bits are sent per frame. After the last drive strobe, `tx_sd` is 0 until the next frame start.
- R4: When `cfg_right_just`=0, the transmit sample is the top bits of the buffer word (bits 31 down to 32-N). When it is 1, the sample is bits N-1 down to 0. Other bits of the word are ignored.
- R5: When `cfg_lsb_first`=0, the sample's most significant bit is sent first. When it is 1, bit 0 is sent first.
- R6: The first bit appears on `tx_sd` in the cycle after the frame-start cycle. `tx_sd` moves to the next bit once per drive strobe and does not change otherwise.
- R7: A frame start without `tx_valid` sets `underrun`, which then stays set until reset. With `cfg_repeat_last`=0, `tx_sd` stays 0 for that frame.
- R8: With `cfg_repeat_last`=1, a frame start without `tx_valid` sends the last accepted buffer word again, using the current settings.
- R9: After a frame start, one `rx_sd` bit is captured per sample strobe. After N bits, `rx_word` holds the sample, with its bit order set by `cfg_lsb_first` and its placement set by `cfg_right_just` as in R4. Unused bits are zero-filled. `rx_valid` rises in the cycle after the last strobe.
- R10: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_word` does not change. A cycle with both high clears `rx_valid`.
- R11: A receive word that completes while the previous word is still unaccepted is dropped, and `overrun` is set. `overrun` stays set until reset.
- R12: A frame start in the middle of a word restarts both paths. Transmit begins the new word, and the partly received bits are discarded without raising `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | 2 | Sample size code (0: 8, 1: 16, 2/3: 32 bits) |
| cfg_right_just | input | 1 | 1 = sample at low end of buffer word |
| cfg_lsb_first | input | 1 | 1 = least significant bit on the line first |
| cfg_repeat_last | input | 1 | 1 = resend last word on underrun |
| frame_start | input | 1 | Frame-start strobe |
| drive_stb | input | 1 | Transmit bit-advance strobe |
| sample_stb | input | 1 | Receive bit-capture strobe |
| tx_word | input | 32 | Transmit buffer word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken this cycle |
| tx_sd | output | 1 | Serial transmit data |
| rx_sd | input | 1 | Serial receive data |
| rx_word | output | 32 | Received buffer word |
| rx_valid | output | 1 | Received word pending |
| rx_ready | input | 1 | Consumer takes the received word |
| underrun | output | 1 | Sticky transmit underrun flag |
| overrun | output | 1 | Sticky receive overrun flag |

## Verification
The bench sweeps every combination of size code, justification and bit order. For each combination it uses three buffer words whose top and bottom halves differ, plus filler bits, so that picking the wrong bit field, reversing the order wrongly or padding with the wrong value each give a different serial pattern. The receive side is fed an independent sample in the same frames. Its result is checked for placement and zero fill, so a shift in the wrong direction cannot pass as correct. Separate sequences cover three cases: a starved frame start in pause mode and in repeat mode (a line of all zeros versus the replayed word), two unacknowledged receive words (the first is kept and overrun is set), and a frame start part way through a word.

// File: rtl/aud_shift_pkg.sv
package aud_shift_pkg;

  localparam int unsigned BUF_W = 32;
  localparam int unsigned CNT_W = $clog2(BUF_W) + 1;

  typedef enum logic [1:0] {
    SZ_QUARTER = 2'd0,
    SZ_HALF    = 2'd1,
    SZ_FULL    = 2'd2,
    SZ_FULL_B  = 2'd3
  } size_e;

  typedef struct packed {
    size_e size;
    logic  right_just;
    logic  lsb_first;
    logic  repeat_last;
  } shift_cfg_t;

  function automatic logic [CNT_W-1:0] sample_len(input size_e code);
    case (code)
      SZ_QUARTER: return CNT_W'(BUF_W / 4);
      SZ_HALF:    return CNT_W'(BUF_W / 2);
      default:    return CNT_W'(BUF_W);
    endcase
  endfunction

  function automatic logic [BUF_W-1:0] bit_rev(input logic [BUF_W-1:0] v);
    logic [BUF_W-1:0] r;
    for (int i = 0; i < BUF_W; i++) r[i] = v[BUF_W-1-i];
    return r;
  endfunction

  // Puts the sample in line order with the first bit to send at the top.
  function automatic logic [BUF_W-1:0] tx_order(input logic [BUF_W-1:0] word,
                                                input shift_cfg_t cfg);
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] pad;
    logic [BUF_W-1:0] top_al;
    len = sample_len(cfg.size);
    pad = CNT_W'(BUF_W) - len;
    if (cfg.right_just) top_al = word << pad;
    else                top_al = word & ~({BUF_W{1'b1}} >> len);
    return cfg.lsb_first ? bit_rev(top_al >> pad) : top_al;
  endfunction

  // acc holds received bits, first one at position len-1, zeros above.
  function automatic logic [BUF_W-1:0] rx_place(input logic [BUF_W-1:0] acc,
                                                input shift_cfg_t cfg);
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] pad;
    logic [BUF_W-1:0] smp;
    len = sample_len(cfg.size);
    pad = CNT_W'(BUF_W) - len;
    smp = cfg.lsb_first ? (bit_rev(acc) >> pad) : acc;
    return cfg.right_just ? smp : (smp << pad);
  endfunction

endpackage

// File: rtl/aud_tx_serializer.sv
module aud_tx_serializer
  import aud_shift_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  shift_cfg_t       cfg,
  input  logic             frame_start,
  input  logic             drive_stb,
  input  logic [BUF_W-1:0] word_in,
  input  logic             word_valid,
  output logic             word_ready,
  output logic             sd_out,
  output logic             underrun_o
);

  logic [BUF_W-1:0] shreg;
  logic [BUF_W-1:0] last_word;
  logic [CNT_W-1:0] remain;
  logic             take;

  assign word_ready = frame_start;
  assign take       = frame_start && word_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      last_word  <= '0;
      remain     <= '0;
      underrun_o <= 1'b0;
    end else if (frame_start) begin
      if (take) begin
        last_word <= word_in;
        shreg     <= tx_order(word_in, cfg);
        remain    <= sample_len(cfg.size);
      end else begin
        underrun_o <= 1'b1;
        if (cfg.repeat_last) begin
          shreg  <= tx_order(last_word, cfg);
          remain <= sample_len(cfg.size);
        end else begin
          shreg  <= '0;
          remain <= '0;
        end
      end
    end else if (drive_stb && remain != '0) begin
      shreg  <= {shreg[BUF_W-2:0], 1'b0};
      remain <= remain - 1'b1;
    end
  end

  assign sd_out = (remain != '0) && shreg[BUF_W-1];

  // R7
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> underrun_o);

  // R7
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !word_valid) |=> underrun_o);

  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !drive_stb) |=> $stable(sd_out));

endmodule

// File: rtl/aud_rx_deserializer.sv
module aud_rx_deserializer
  import aud_shift_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  shift_cfg_t       cfg,
  input  logic             frame_start,
  input  logic             sample_stb,
  input  logic             sd_in,
  output logic [BUF_W-1:0] word_out,
  output logic             word_valid,
  input  logic             word_ready,
  output logic             overrun_o
);

  logic [BUF_W-1:0] acc;
  logic [BUF_W-1:0] acc_next;
  logic [CNT_W-1:0] remain;
  logic             capture;
  logic             done;

  assign capture  = !frame_start && sample_stb && (remain != '0);
  assign done     = capture && (remain == CNT_W'(1));
  assign acc_next = {acc[BUF_W-2:0], sd_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      remain <= '0;
    end else if (frame_start) begin
      acc    <= '0;
      remain <= sample_len(cfg.size);
    end else if (capture) begin
      acc    <= acc_next;
      remain <= remain - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out   <= '0;
      word_valid <= 1'b0;
      overrun_o  <= 1'b0;
    end else if (done) begin
      if (word_valid && !word_ready) begin
        overrun_o <= 1'b1;
      end else begin
        word_out   <= rx_place(acc_next, cfg);
        word_valid <= 1'b1;
      end
    end else if (word_valid && word_ready) begin
      word_valid <= 1'b0;
    end
  end

  // R10
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_out)));

  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  // R9
  valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> $past(sample_stb));

endmodule

// File: rtl/audio_shifter.sv
module audio_shifter
  import aud_shift_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_size,
  input  logic        cfg_right_just,
  input  logic        cfg_lsb_first,
  input  logic        cfg_repeat_last,
  input  logic        frame_start,
  input  logic        drive_stb,
  input  logic        sample_stb,
  input  logic [31:0] tx_word,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic        tx_sd,
  input  logic        rx_sd,
  output logic [31:0] rx_word,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic        underrun,
  output logic        overrun
);

  shift_cfg_t cfg;

  assign cfg.size        = size_e'(cfg_size);
  assign cfg.right_just  = cfg_right_just;
  assign cfg.lsb_first   = cfg_lsb_first;
  assign cfg.repeat_last = cfg_repeat_last;

  aud_tx_serializer u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .frame_start (frame_start),
    .drive_stb   (drive_stb),
    .word_in     (tx_word),
    .word_valid  (tx_valid),
    .word_ready  (tx_ready),
    .sd_out      (tx_sd),
    .underrun_o  (underrun)
  );

  aud_rx_deserializer u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .frame_start (frame_start),
    .sample_stb  (sample_stb),
    .sd_in       (rx_sd),
    .word_out    (rx_word),
    .word_valid  (rx_valid),
    .word_ready  (rx_ready),
    .overrun_o   (overrun)
  );

  // R2
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> frame_start);

endmodule

// File: tb/test_audio_shifter.sv
`timescale 1ns/1ps
module test_audio_shifter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_size;
  logic        cfg_right_just, cfg_lsb_first, cfg_repeat_last;
  logic        frame_start, drive_stb, sample_stb;
  logic [31:0] tx_word;
  logic        tx_valid, tx_ready, tx_sd, rx_sd;
  logic [31:0] rx_word;
  logic        rx_valid, rx_ready, underrun, overrun;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  audio_shifter i_audio_shifter (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_right_just(cfg_right_just),
    .cfg_lsb_first(cfg_lsb_first), .cfg_repeat_last(cfg_repeat_last),
    .frame_start(frame_start), .drive_stb(drive_stb), .sample_stb(sample_stb),
    .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sd(tx_sd),
    .rx_sd(rx_sd), .rx_word(rx_word), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .underrun(underrun), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int len_of(input int sz);
    return (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] mask_of(input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  // Runs one frame. txsrc: word whose sample should appear on tx_sd (0 for pause).
  // rsample: sample driven on rx_sd. rexp: sample expected in rx_word afterwards.
  task automatic run_frame(input int sz, input bit rj, input bit lsb,
                           input logic [31:0] w, input bit give,
                           input logic [31:0] txsrc,
                           input logic [31:0] rsample, input logic [31:0] rexp,
                           input bit ack);
    int n;
    logic [31:0] s, rw;
    n = len_of(sz);
    cfg_size = 2'(sz); cfg_right_just = rj; cfg_lsb_first = lsb;
    s = rj ? (txsrc & mask_of(n)) : (txsrc >> (32 - n));
    @(negedge clk);
    frame_start = 1'b1; tx_valid = give; tx_word = w;
    #0.1;
    chk("R2 tx_ready at frame start", {31'd0, tx_ready}, 32'd1);
    @(negedge clk);
    frame_start = 1'b0; tx_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk("R4/R5/R6 tx bit", {31'd0, tx_sd}, {31'd0, lsb ? s[i] : s[n-1-i]});
      rx_sd = lsb ? rsample[i] : rsample[n-1-i];
      drive_stb = 1'b1; sample_stb = 1'b1;
      @(negedge clk);
      drive_stb = 1'b0; sample_stb = 1'b0;
    end
    chk("R3 line idle after last bit", {31'd0, tx_sd}, 32'd0);
    rw = rj ? (rexp & mask_of(n)) : ((rexp & mask_of(n)) << (32 - n));
    chk("R9 rx_valid", {31'd0, rx_valid}, 32'd1);
    chk("R9 rx_word", rx_word, rw);
    if (ack) begin
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
      chk("R10 rx_valid cleared", {31'd0, rx_valid}, 32'd0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3];
    logic [31:0] rs, r1;
    pats[0] = 32'hA5C3_96E1;
    pats[1] = 32'h0F1E_2D3C;
    pats[2] = 32'hF00D_8001;
    rst_n = 1'b0; cfg_size = 2'd0; cfg_right_just = 1'b0; cfg_lsb_first = 1'b0;
    cfg_repeat_last = 1'b0; frame_start = 1'b0; drive_stb = 1'b0; sample_stb = 1'b0;
    tx_word = '0; tx_valid = 1'b0; rx_sd = 1'b0; rx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 tx_sd", {31'd0, tx_sd}, 32'd0);
    chk("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
    chk("R1 underrun", {31'd0, underrun}, 32'd0);
    chk("R1 overrun", {31'd0, overrun}, 32'd0);

    // Sweep: size x justification x order x pattern
    for (int sz = 0; sz < 3; sz++)
      for (int rj = 0; rj < 2; rj++)
        for (int lsb = 0; lsb < 2; lsb++)
          for (int p = 0; p < 3; p++) begin
            rs = pats[(p + 1) % 3] ^ 32'h3C3C_5A5A;
            run_frame(sz, rj[0], lsb[0], pats[p], 1'b1, pats[p], rs, rs, 1'b1);
          end
    // R3 code 3 behaves as 32 bits
    run_frame(3, 1'b0, 1'b0, 32'h8421_1248, 1'b1, 32'h8421_1248, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1);
    chk("R7 no false underrun", {31'd0, underrun}, 32'd0);
    chk("R11 no false overrun", {31'd0, overrun}, 32'd0);

    // R12: restart mid-word
    cfg_size = 2'd1; cfg_right_just = 1'b1; cfg_lsb_first = 1'b0;
    @(negedge clk); frame_start = 1'b1; tx_valid = 1'b1; tx_word = 32'h0000_FFFF;
    @(negedge clk); frame_start = 1'b0; tx_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      rx_sd = 1'b1; drive_stb = 1'b1; sample_stb = 1'b1;
      @(negedge clk); drive_stb = 1'b0; sample_stb = 1'b0;
    end
    run_frame(1, 1'b1, 1'b0, 32'h0000_1234, 1'b1, 32'h0000_1234, 32'h0000_00F0, 32'h0000_00F0, 1'b1);
    chk("R12 restart no extra word", {31'd0, rx_valid}, 32'd0);

    // R7: pause mode underrun -> zeros
    cfg_repeat_last = 1'b0;
    run_frame(0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, 32'h0, 32'h0000_0055, 32'h0000_0055, 1'b1);
    chk("R7 underrun set", {31'd0, underrun}, 32'd1);

    // R8: repeat mode replays last accepted word (0x0000_1234)
    cfg_repeat_last = 1'b1;
    run_frame(1, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0000_1234, 32'h0000_A00A, 32'h0000_A00A, 1'b1);
    run_frame(0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0000_1234, 32'h0000_0081, 32'h0000_0081, 1'b1);
    chk("R7 underrun sticky", {31'd0, underrun}, 32'd1);

    // R11: two unacknowledged receive words
    cfg_repeat_last = 1'b0;
    r1 = 32'h0000_00C6;
    run_frame(0, 1'b1, 1'b0, 32'h0000_0011, 1'b1, 32'h0000_0011, r1, r1, 1'b0);
    chk("R11 no overrun yet", {31'd0, overrun}, 32'd0);
    run_frame(0, 1'b1, 1'b0, 32'h0000_0022, 1'b1, 32'h0000_0022, 32'h0000_0039, r1, 1'b0);
    chk("R11 overrun set", {31'd0, overrun}, 32'd1);
    chk("R10 first word kept", rx_word, r1);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    chk("R10 released", {31'd0, rx_valid}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R11 overrun sticky", {31'd0, overrun}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule